// File: doc/BRIEF.md
# Address-Mapped Flash Command Decoder

This block sits between a 32-bit memory-mapped bus and the request side of a NAND-style flash controller. Each bus access carries its meaning in the address. An 8-bit access class sits in the top byte. The low 24 bits give a flash location (block, page, sector) or a register word. Accesses to the data class become a stream of word strobes. A running index in that stream covers the main area of a page and, when enabled, the spare area after it. Writes to the command class carry an operation code in the data word. The block turns these into erase, verify, unlock-all and ranged lock/unlock/lock-tight requests for the flash back end.

The block keeps a small per-block protection table. It uses this table to refuse programs and erases aimed at protected blocks. Refused accesses raise a sticky error that is cleared by writing 1. Ranged commands need a start code followed by an end code of the same kind. While a back-end request is outstanding, the bus is stalled until the back end signals completion. A parameter chooses between two placements of the block, page and sector fields.

Top module: `flash_cmd_decoder`

## Requirements
- R1: After reset, bus_ready is 1, req_valid is 0, both error flags are 0, and every tracked block is protected (state locked). A data-class write to any block then gives no wr_stb and sets locked_err.
- R2: The access class is bus_addr[31:24]: 0x00 and 0x03 are register classes, 0x01 is the data port, 0x02 is the command port, and other values are accepted and ignored. With LAYOUT=0 the block index starts at bit 10, the page at bit 4 and the sector at bit 2. With LAYOUT=1 they start at bits 12, 6 and 4. The block field runs up to bit 23, and requests report it at full width.
- R3: Each accepted data-port write to an unprotected block raises wr_stb in the same cycle, with wr_data equal to bus_wdata. word_idx counts 0,1,...,MAIN_WORDS-1 and then wraps, as long as block and page stay the same. The sector field does not affect the count. A different block or page restarts the count at 0.
- R4: Register word 1, bit 0 is the spare enable. When it is 1, the stream per page is MAIN_WORDS main words followed by SPARE_WORDS spare words, with word_spare=1 exactly for indices MAIN_WORDS and above, and then it wraps. The register reads back its value.
- R5: An accepted data-port read raises rd_stb, returns rd_word on bus_rdata in the same cycle, and advances the same word index.
- R6: Command writes: 0x03 requests an erase (op 1) of the addressed block when it is unprotected. 0x15 requests an erase-verify (op 2) regardless of protection. 0x0E requests unlock-all (op 3) and unprotects every block that is not locked-tight. Erase and verify report the block as both req_blk_lo and req_blk_hi.
- R7: A range start code is 0x08 (unlock), 0x0A (lock) or 0x0C (lock-tight). A later end code of the same kind (0x09, 0x0B, 0x0D) issues op 4, 5 or 6 with req_blk_lo/hi set to the smaller and larger of the two block indices. It also applies the new state to every tracked block in that range.
- R8: An end code with no pending start of the same kind issues no request, changes no protection state and sets seq_err. Any end code clears the pending start.
- R9: A locked-tight block stays protected through unlock ranges and unlock-all, until reset.
- R10: From the cycle after a request is issued, req_valid holds with a stable op until req_ready, and bus_ready stays 0 until the cycle after req_done. With the back end answering N cycles after req_valid rises, bus_ready is low for N+1 cycles.
- R11: An erase or data-port write to a protected block issues nothing and sets locked_err. Writing 1 to register word 0 bit 0 clears locked_err, and writing 0 leaves it set. Bit 1 works the same way for seq_err.
- R12: In class 0x00 the register word is the low 24 address bits shifted right by 1. In class 0x03 they are shifted right by 2. Word 0 reads {seq_err, locked_err} in bits 1:0.
- R13: Command codes other than those listed issue no request and change no flag.
- R14: Protection tracking uses the low BLK_W bits of the block index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_valid | input | 1 | Bus access request |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 32 | Class in [31:24], location or register in [23:0] |
| bus_wdata | input | 32 | Write data or command code |
| bus_ready | output | 1 | Access accepted when high with bus_valid |
| bus_rdata | output | 32 | Read data, valid in the accepting cycle |
| wr_stb | output | 1 | Data-port write word strobe |
| wr_data | output | 32 | Word for wr_stb |
| rd_stb | output | 1 | Data-port read word strobe |
| rd_word | input | 32 | Word returned by the back end for rd_stb |
| word_idx | output | IDX_W | Position of the word within the page stream |
| word_spare | output | 1 | Current word belongs to the spare area |
| req_valid | output | 1 | Flash operation request pending |
| req_ready | input | 1 | Back end takes the request |
| req_done | input | 1 | Back end finished the operation |
| req_op | output | 3 | Operation code (1 erase ... 6 lock-tight) |
| req_blk_lo | output | BLK_FW | First block of the operation |
| req_blk_hi | output | BLK_FW | Last block of the operation |
| locked_err | output | 1 | Sticky protected-block access error |
| seq_err | output | 1 | Sticky range sequence error |

## Verification
If a protection entry is corrupted, it shows up at once as a missing or extra wr_stb. It also shows up as a locked_err, or as an erase request that appears where none is expected or vanishes where one is. Sweeping programs over every tracked block after each table change exposes the fault on the next sweep. A stale pending range start shows up as a request, or a missing seq_err, on the very next end code. A word counter that drifts shows up as a wrong word_idx or word_spare on the next data access. A busy flag that never clears shows up as bus_ready stuck low, which the watchdog catches.

// File: rtl/fcd_pkg.sv
package fcd_pkg;

    localparam int LOC_W = 24;

    localparam logic [7:0] CLS_REG_H = 8'h00;
    localparam logic [7:0] CLS_DATA  = 8'h01;
    localparam logic [7:0] CLS_CMD   = 8'h02;
    localparam logic [7:0] CLS_REG_W = 8'h03;

    localparam logic [31:0] CODE_ERASE      = 32'h03;
    localparam logic [31:0] CODE_UNL_START  = 32'h08;
    localparam logic [31:0] CODE_UNL_END    = 32'h09;
    localparam logic [31:0] CODE_LCK_START  = 32'h0A;
    localparam logic [31:0] CODE_LCK_END    = 32'h0B;
    localparam logic [31:0] CODE_TGT_START  = 32'h0C;
    localparam logic [31:0] CODE_TGT_END    = 32'h0D;
    localparam logic [31:0] CODE_UNLOCK_ALL = 32'h0E;
    localparam logic [31:0] CODE_VERIFY     = 32'h15;

    typedef enum logic [2:0] {
        OP_NONE       = 3'd0,
        OP_ERASE      = 3'd1,
        OP_VERIFY     = 3'd2,
        OP_UNLOCK_ALL = 3'd3,
        OP_UNLOCK     = 3'd4,
        OP_LOCK       = 3'd5,
        OP_TIGHT      = 3'd6
    } op_t;

    typedef enum logic [1:0] {
        PR_OPEN   = 2'd0,
        PR_LOCKED = 2'd1,
        PR_TIGHT  = 2'd2
    } prot_t;

    typedef enum logic [1:0] {
        RK_NONE   = 2'd0,
        RK_UNLOCK = 2'd1,
        RK_LOCK   = 2'd2,
        RK_TIGHT  = 2'd3
    } range_t;

    function automatic int blk_shift(input int layout);
        return (layout == 0) ? 10 : 12;
    endfunction

    function automatic int pg_shift(input int layout);
        return (layout == 0) ? 4 : 6;
    endfunction

    function automatic int blk_fw(input int layout);
        return LOC_W - blk_shift(layout);
    endfunction

    function automatic int pg_fw(input int layout);
        return blk_shift(layout) - pg_shift(layout);
    endfunction

    function automatic range_t start_kind(input logic [31:0] code);
        case (code)
            CODE_UNL_START: return RK_UNLOCK;
            CODE_LCK_START: return RK_LOCK;
            CODE_TGT_START: return RK_TIGHT;
            default:        return RK_NONE;
        endcase
    endfunction

    function automatic range_t end_kind(input logic [31:0] code);
        case (code)
            CODE_UNL_END: return RK_UNLOCK;
            CODE_LCK_END: return RK_LOCK;
            CODE_TGT_END: return RK_TIGHT;
            default:      return RK_NONE;
        endcase
    endfunction

    function automatic op_t kind_op(input range_t k);
        case (k)
            RK_UNLOCK: return OP_UNLOCK;
            RK_LOCK:   return OP_LOCK;
            RK_TIGHT:  return OP_TIGHT;
            default:   return OP_NONE;
        endcase
    endfunction

endpackage

// File: rtl/fcd_addr_split.sv
module fcd_addr_split
    import fcd_pkg::*;
#(
    parameter int LAYOUT = 0,
    localparam int BS     = blk_shift(LAYOUT),
    localparam int PS     = pg_shift(LAYOUT),
    localparam int BLK_FW = blk_fw(LAYOUT),
    localparam int PG_FW  = pg_fw(LAYOUT)
) (
    input  logic [31:0]       addr,
    output logic [7:0]        cls,
    output logic [BLK_FW-1:0] blk,
    output logic [PG_FW-1:0]  pg,
    output logic [LOC_W-1:0]  reg_word
);
    logic [LOC_W-1:0] loc;
    logic             unused_lsb;

    assign cls        = addr[31:24];
    assign loc        = addr[LOC_W-1:0];
    assign blk        = loc[LOC_W-1:BS];
    assign pg         = loc[BS-1:PS];
    assign unused_lsb = loc[0];

    // Class 0x00 addresses half-word registers, class 0x03 word registers.
    always_comb begin
        if (cls == CLS_REG_W) reg_word = loc >> 2;
        else                  reg_word = loc >> 1;
    end
endmodule

// File: rtl/fcd_word_ctr.sv
module fcd_word_ctr #(
    parameter int MAIN   = 8,
    parameter int SPARE  = 2,
    parameter int LOC_W  = 20,
    localparam int IDX_W = $clog2(MAIN + SPARE)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             step,
    input  logic [LOC_W-1:0] loc,
    input  logic             spare_en,
    output logic [IDX_W-1:0] idx,
    output logic             in_spare
);
    localparam logic [IDX_W:0] MAIN_N = (IDX_W + 1)'(MAIN);
    localparam logic [IDX_W:0] TOT_N  = (IDX_W + 1)'(MAIN + SPARE);

    logic [IDX_W:0]   cnt, cur, nxt, total;
    logic [LOC_W-1:0] last_loc;
    logic             have_loc;
    logic             unused_top;

    always_comb begin
        total = spare_en ? TOT_N : MAIN_N;
        if (have_loc && (loc == last_loc) && (cnt < total)) cur = cnt;
        else                                                cur = '0;
        nxt = ((cur + 1'b1) == total) ? '0 : (cur + 1'b1);
    end

    assign idx        = cur[IDX_W-1:0];
    assign in_spare   = (cur >= MAIN_N);
    assign unused_top = cur[IDX_W];

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt      <= '0;
            last_loc <= '0;
            have_loc <= 1'b0;
        end else if (step) begin
            cnt      <= nxt;
            last_loc <= loc;
            have_loc <= 1'b1;
        end
    end
endmodule

// File: rtl/fcd_prot_table.sv
module fcd_prot_table
    import fcd_pkg::*;
#(
    parameter int BLK_W = 3,
    localparam int NB   = 1 << BLK_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             upd,
    input  op_t              upd_op,
    input  logic [BLK_W-1:0] lo,
    input  logic [BLK_W-1:0] hi,
    input  logic [BLK_W-1:0] query,
    output logic             q_open
);
    logic [NB-1:0] open_vec;

    for (genvar g = 0; g < NB; g++) begin : g_ent
        localparam logic [BLK_W-1:0] ME = BLK_W'(g);
        prot_t st;
        logic  in_rng;

        assign in_rng      = (ME >= lo) && (ME <= hi);
        assign open_vec[g] = (st == PR_OPEN);

        always_ff @(posedge clk) begin
            if (rst) begin
                st <= PR_LOCKED;
            end else if (upd) begin
                case (upd_op)
                    OP_UNLOCK_ALL: if (st != PR_TIGHT) st <= PR_OPEN;
                    OP_UNLOCK:     if (in_rng && st != PR_TIGHT) st <= PR_OPEN;
                    OP_LOCK:       if (in_rng && st != PR_TIGHT) st <= PR_LOCKED;
                    OP_TIGHT:      if (in_rng) st <= PR_TIGHT;
                    default:       ;
                endcase
            end
        end
    end

    assign q_open = open_vec[query];
endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder
    import fcd_pkg::*;
#(
    parameter int LAYOUT      = 0,
    parameter int MAIN_WORDS  = 8,
    parameter int SPARE_WORDS = 2,
    parameter int BLK_W       = 3,
    localparam int IDX_W      = $clog2(MAIN_WORDS + SPARE_WORDS),
    localparam int BLK_FW     = blk_fw(LAYOUT)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [31:0]       bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic              bus_ready,
    output logic [31:0]       bus_rdata,
    output logic              wr_stb,
    output logic [31:0]       wr_data,
    output logic              rd_stb,
    input  logic [31:0]       rd_word,
    output logic [IDX_W-1:0]  word_idx,
    output logic              word_spare,
    output logic              req_valid,
    input  logic              req_ready,
    input  logic              req_done,
    output logic [2:0]        req_op,
    output logic [BLK_FW-1:0] req_blk_lo,
    output logic [BLK_FW-1:0] req_blk_hi,
    output logic              locked_err,
    output logic              seq_err
);
    localparam int PG_FW = pg_fw(LAYOUT);

    logic [7:0]        cls;
    logic [BLK_FW-1:0] blk;
    logic [PG_FW-1:0]  pg;
    logic [LOC_W-1:0]  reg_word;

    logic busy, spare_en, blk_open;
    logic acc, acc_wr, data_acc, reg_cls, reg_wr;

    range_t            pend_kind, sk, ek;
    logic [BLK_FW-1:0] pend_blk;

    logic              iss, set_lk, set_sq, pend_wr;
    op_t               iss_op;
    range_t            pend_kind_n;
    logic [BLK_FW-1:0] iss_lo, iss_hi;

    fcd_addr_split #(.LAYOUT(LAYOUT)) u_split (
        .addr     (bus_addr),
        .cls      (cls),
        .blk      (blk),
        .pg       (pg),
        .reg_word (reg_word)
    );

    assign bus_ready = ~busy;
    assign acc       = bus_valid & bus_ready;
    assign acc_wr    = acc & bus_write;
    assign data_acc  = acc & (cls == CLS_DATA);
    assign reg_cls   = (cls == CLS_REG_H) || (cls == CLS_REG_W);
    assign reg_wr    = acc_wr & reg_cls;

    assign wr_stb  = data_acc & bus_write & blk_open;
    assign wr_data = bus_wdata;
    assign rd_stb  = data_acc & ~bus_write;

    fcd_word_ctr #(
        .MAIN  (MAIN_WORDS),
        .SPARE (SPARE_WORDS),
        .LOC_W (BLK_FW + PG_FW)
    ) u_ctr (
        .clk      (clk),
        .rst      (rst),
        .step     (data_acc),
        .loc      ({blk, pg}),
        .spare_en (spare_en),
        .idx      (word_idx),
        .in_spare (word_spare)
    );

    fcd_prot_table #(.BLK_W(BLK_W)) u_prot (
        .clk    (clk),
        .rst    (rst),
        .upd    (iss),
        .upd_op (iss_op),
        .lo     (iss_lo[BLK_W-1:0]),
        .hi     (iss_hi[BLK_W-1:0]),
        .query  (blk[BLK_W-1:0]),
        .q_open (blk_open)
    );

    assign sk = start_kind(bus_wdata);
    assign ek = end_kind(bus_wdata);

    // Command decode: the data word written to the command class picks the operation.
    always_comb begin
        iss         = 1'b0;
        iss_op      = OP_ERASE;
        iss_lo      = blk;
        iss_hi      = blk;
        set_lk      = 1'b0;
        set_sq      = 1'b0;
        pend_wr     = 1'b0;
        pend_kind_n = RK_NONE;
        if (acc_wr && cls == CLS_DATA && !blk_open) set_lk = 1'b1;
        if (acc_wr && cls == CLS_CMD) begin
            if (sk != RK_NONE) begin
                pend_wr     = 1'b1;
                pend_kind_n = sk;
            end else if (ek != RK_NONE) begin
                pend_wr = 1'b1;
                if (pend_kind == ek) begin
                    iss    = 1'b1;
                    iss_op = kind_op(ek);
                    iss_lo = (pend_blk < blk) ? pend_blk : blk;
                    iss_hi = (pend_blk < blk) ? blk : pend_blk;
                end else begin
                    set_sq = 1'b1;
                end
            end else begin
                case (bus_wdata)
                    CODE_ERASE: begin
                        if (blk_open) iss = 1'b1;
                        else          set_lk = 1'b1;
                    end
                    CODE_VERIFY: begin
                        iss    = 1'b1;
                        iss_op = OP_VERIFY;
                    end
                    CODE_UNLOCK_ALL: begin
                        iss    = 1'b1;
                        iss_op = OP_UNLOCK_ALL;
                        iss_lo = '0;
                        iss_hi = '1;
                    end
                    default: ;
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_kind <= RK_NONE;
            pend_blk  <= '0;
        end else if (pend_wr) begin
            pend_kind <= pend_kind_n;
            pend_blk  <= blk;
        end
    end

    // Request register and bus stall.
    always_ff @(posedge clk) begin
        if (rst) begin
            req_valid  <= 1'b0;
            busy       <= 1'b0;
            req_op     <= OP_NONE;
            req_blk_lo <= '0;
            req_blk_hi <= '0;
        end else if (iss) begin
            req_valid  <= 1'b1;
            busy       <= 1'b1;
            req_op     <= iss_op;
            req_blk_lo <= iss_lo;
            req_blk_hi <= iss_hi;
        end else begin
            if (req_ready || req_done) req_valid <= 1'b0;
            if (req_done)              busy      <= 1'b0;
        end
    end

    // Status and configuration registers.
    always_ff @(posedge clk) begin
        if (rst) begin
            locked_err <= 1'b0;
            seq_err    <= 1'b0;
            spare_en   <= 1'b0;
        end else begin
            if (set_lk)                                             locked_err <= 1'b1;
            else if (reg_wr && reg_word == '0 && bus_wdata[0])      locked_err <= 1'b0;
            if (set_sq)                                             seq_err    <= 1'b1;
            else if (reg_wr && reg_word == '0 && bus_wdata[1])      seq_err    <= 1'b0;
            if (reg_wr && reg_word == LOC_W'(1))                    spare_en   <= bus_wdata[0];
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (cls == CLS_DATA) bus_rdata = rd_word;
        else if (reg_cls) begin
            if (reg_word == '0)            bus_rdata = {30'd0, seq_err, locked_err};
            else if (reg_word == LOC_W'(1)) bus_rdata = {31'd0, spare_en};
        end
    end
endmodule

// File: rtl/fcd_chk.sv
module fcd_chk #(
    parameter int MAIN  = 8,
    parameter int TOTAL = 10,
    parameter int IDX_W = 4
) (
    input logic             clk,
    input logic             rst,
    input logic             bus_valid,
    input logic             bus_write,
    input logic [31:0]      bus_addr,
    input logic             bus_ready,
    input logic             wr_stb,
    input logic             rd_stb,
    input logic [IDX_W-1:0] word_idx,
    input logic             word_spare,
    input logic             req_valid,
    input logic             req_ready,
    input logic             req_done,
    input logic [2:0]       req_op,
    input logic             locked_err,
    input logic             seq_err
);
    localparam logic [IDX_W:0] MAIN_N = (IDX_W + 1)'(MAIN);
    localparam logic [IDX_W:0] TOT_N  = (IDX_W + 1)'(TOTAL);

    p_stall_while_pending_r10: assert property (@(posedge clk) disable iff (rst)
        req_valid |-> !bus_ready);

    p_hold_until_taken_r10: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_ready && !req_done) |=> (req_valid && $stable(req_op)));

    p_one_strobe_r3: assert property (@(posedge clk) disable iff (rst)
        $onehot0({wr_stb, rd_stb}));

    p_idx_bound_r4: assert property (@(posedge clk) disable iff (rst)
        (wr_stb || rd_stb) |-> ({1'b0, word_idx} < TOT_N));

    p_spare_after_main_r4: assert property (@(posedge clk) disable iff (rst)
        word_spare |-> ({1'b0, word_idx} >= MAIN_N));

    p_lock_err_cause_r11: assert property (@(posedge clk) disable iff (rst)
        $rose(locked_err) |-> $past(bus_valid && bus_ready && bus_write));

    p_seq_err_cause_r8: assert property (@(posedge clk) disable iff (rst)
        $rose(seq_err) |-> $past(bus_valid && bus_ready && bus_write && bus_addr[31:24] == 8'h02));

    p_issue_on_cmd_r6: assert property (@(posedge clk) disable iff (rst)
        $rose(req_valid) |-> $past(bus_valid && bus_ready && bus_write && bus_addr[31:24] == 8'h02));
endmodule

bind flash_cmd_decoder fcd_chk #(
    .MAIN  (MAIN_WORDS),
    .TOTAL (MAIN_WORDS + SPARE_WORDS),
    .IDX_W (IDX_W)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .bus_valid  (bus_valid),
    .bus_write  (bus_write),
    .bus_addr   (bus_addr),
    .bus_ready  (bus_ready),
    .wr_stb     (wr_stb),
    .rd_stb     (rd_stb),
    .word_idx   (word_idx),
    .word_spare (word_spare),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .req_done   (req_done),
    .req_op     (req_op),
    .locked_err (locked_err),
    .seq_err    (seq_err)
);

// File: tb/flash_cmd_decoder_tb.sv
module flash_cmd_decoder_tb;
    localparam int CLK_PERIOD = 10;
    localparam int MAIN  = 8;
    localparam int SPARE = 2;
    localparam int NBLK  = 8;
    localparam int BS    = 10;
    localparam int PS    = 4;
    localparam int SS    = 2;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_valid = 1'b0, bus_write = 1'b0;
    logic [31:0] bus_addr = '0, bus_wdata = '0, rd_word = '0;
    logic        bus_ready, wr_stb, rd_stb, word_spare, req_valid;
    logic [31:0] bus_rdata, wr_data;
    logic [3:0]  word_idx;
    logic        req_ready, req_done, locked_err, seq_err;
    logic [2:0]  req_op;
    logic [13:0] req_blk_lo, req_blk_hi;

    int checks = 0, errors = 0;
    int resp_delay = 0, wait_cnt = 0, req_cnt = 0;
    logic [2:0]  last_op;
    logic [13:0] last_lo, last_hi;
    int mdl [NBLK];

    logic        s_wr, s_rd, s_spare;
    logic [3:0]  s_idx;
    logic [31:0] s_rdata, s_wdata;

    always #(CLK_PERIOD / 2) clk = ~clk;

    flash_cmd_decoder u_dut (
        .clk(clk), .rst(rst), .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_ready(bus_ready),
        .bus_rdata(bus_rdata), .wr_stb(wr_stb), .wr_data(wr_data), .rd_stb(rd_stb),
        .rd_word(rd_word), .word_idx(word_idx), .word_spare(word_spare),
        .req_valid(req_valid), .req_ready(req_ready), .req_done(req_done),
        .req_op(req_op), .req_blk_lo(req_blk_lo), .req_blk_hi(req_blk_hi),
        .locked_err(locked_err), .seq_err(seq_err)
    );

    // Back-end model: answers resp_delay cycles after req_valid is seen.
    always @(negedge clk) begin
        if (rst) begin
            req_ready <= 1'b0;
            req_done  <= 1'b0;
            wait_cnt  <= 0;
        end else if (req_valid && !req_ready) begin
            if (wait_cnt == resp_delay) begin
                req_ready <= 1'b1;
                req_done  <= 1'b1;
                req_cnt   <= req_cnt + 1;
                last_op   <= req_op;
                last_lo   <= req_blk_lo;
                last_hi   <= req_blk_hi;
                wait_cnt  <= 0;
            end else begin
                wait_cnt <= wait_cnt + 1;
            end
        end else begin
            req_ready <= 1'b0;
            req_done  <= 1'b0;
        end
    end

    function automatic logic [31:0] fa(input int cls, input int b, input int p, input int s);
        return (32'(cls) << 24) | (32'(b) << BS) | (32'(p) << PS) | (32'(s) << SS);
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic bus_op(input logic wr, input logic [31:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = wr; bus_addr = a; bus_wdata = d;
        while (!bus_ready) @(negedge clk);
        #1;
        s_wr = wr_stb; s_rd = rd_stb; s_idx = word_idx; s_spare = word_spare;
        s_rdata = bus_rdata; s_wdata = wr_data;
        @(posedge clk);
        #1;
        bus_valid = 1'b0;
    endtask

    task automatic settle();
        @(negedge clk);
        while (!bus_ready) @(negedge clk);
    endtask

    task automatic cmd(input int b, input logic [31:0] code);
        bus_op(1'b1, fa(2, b, 0, 0), code);
        settle();
    endtask

    task automatic clear_flags();
        bus_op(1'b1, 32'h0, 32'h3);
        settle();
    endtask

    task automatic prog_sweep(input string tag);
        int any_locked = 0;
        for (int b = 0; b < NBLK; b++) begin
            bus_op(1'b1, fa(1, b, 0, 0), 32'hA500_0000 | 32'(b));
            chk(tag, {31'd0, s_wr}, {31'd0, mdl[b] == 0});
            if (mdl[b] != 0) any_locked = 1;
        end
        settle();
        chk({tag, " locked_err"}, {31'd0, locked_err}, 32'(any_locked));
        clear_flags();
    endtask

    task automatic report();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual hung expected done");
        report();
    end

    initial begin
        int n0;
        for (int b = 0; b < NBLK; b++) mdl[b] = 1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk("R1 bus_ready", {31'd0, bus_ready}, 32'd1);
        chk("R1 req_valid", {31'd0, req_valid}, 32'd0);
        chk("R1 flags", {30'd0, seq_err, locked_err}, 32'd0);
        prog_sweep("R1 all locked after reset");

        // R11 / R12: write-0 keeps flag, write-1 through word-addressed class clears
        bus_op(1'b1, fa(1, 2, 0, 0), 32'h1); settle();
        chk("R11 set", {31'd0, locked_err}, 32'd1);
        bus_op(1'b1, 32'h0, 32'h0); settle();
        chk("R11 write 0 keeps", {31'd0, locked_err}, 32'd1);
        bus_op(1'b0, 32'h0, 32'h0);
        chk("R12 status read half-word class", s_rdata, 32'h1);
        bus_op(1'b1, 32'h0300_0000, 32'h1); settle();
        chk("R11 R12 clear via word class", {31'd0, locked_err}, 32'd0);

        // R6 unlock-all
        n0 = req_cnt;
        cmd(0, 32'h0E);
        chk("R6 unlock-all issued", 32'(req_cnt), 32'(n0 + 1));
        chk("R6 unlock-all op", {29'd0, last_op}, 32'd3);
        for (int b = 0; b < NBLK; b++) mdl[b] = 0;
        prog_sweep("R6 open after unlock-all");

        // R3 stream counting, sector ignored
        for (int i = 0; i < 20; i++) begin
            bus_op(1'b1, fa(1, 1, 3, i % 4), 32'h1000 + 32'(i));
            chk("R3 strobe", {31'd0, s_wr}, 32'd1);
            chk("R3 index", {28'd0, s_idx}, 32'(i % MAIN));
            chk("R3 data", s_wdata, 32'h1000 + 32'(i));
        end
        bus_op(1'b1, fa(1, 1, 4, 0), 32'h0);
        chk("R3 new page restarts", {28'd0, s_idx}, 32'd0);

        // R4 spare area
        bus_op(1'b1, 32'h2, 32'h1);
        bus_op(1'b0, 32'h0300_0004, 32'h0);
        chk("R4 R12 spare enable readback", s_rdata, 32'h1);
        for (int i = 0; i < 25; i++) begin
            bus_op(1'b1, fa(1, 1, 5, 0), 32'(i));
            chk("R4 index", {28'd0, s_idx}, 32'(i % (MAIN + SPARE)));
            chk("R4 spare flag", {31'd0, s_spare}, {31'd0, (i % (MAIN + SPARE)) >= MAIN});
        end
        bus_op(1'b1, 32'h2, 32'h0);

        // R5 reads
        for (int i = 0; i < 3; i++) begin
            rd_word = 32'hC0DE_0000 + 32'(i);
            bus_op(1'b0, fa(1, 2, 1, 0), 32'h0);
            chk("R5 rd_stb", {30'd0, s_rd, s_wr}, 32'h2);
            chk("R5 data", s_rdata, 32'hC0DE_0000 + 32'(i));
            chk("R5 index", {28'd0, s_idx}, 32'(i));
        end

        // R7 lock range, reversed order
        n0 = req_cnt;
        cmd(5, 32'h0A);
        cmd(3, 32'h0B);
        chk("R7 issued", 32'(req_cnt), 32'(n0 + 1));
        chk("R7 op", {29'd0, last_op}, 32'd5);
        chk("R7 lo", {18'd0, last_lo}, 32'd3);
        chk("R7 hi", {18'd0, last_hi}, 32'd5);
        for (int b = 3; b <= 5; b++) mdl[b] = 1;
        prog_sweep("R7 R11 lock range");

        // R8 sequence errors
        n0 = req_cnt;
        cmd(2, 32'h0B);
        chk("R8 lone end flag", {31'd0, seq_err}, 32'd1);
        cmd(1, 32'h08);
        cmd(1, 32'h0B);
        cmd(1, 32'h09);
        chk("R8 no request", 32'(req_cnt), 32'(n0));
        bus_op(1'b1, 32'h0, 32'h2); settle();
        chk("R8 R11 seq clear", {31'd0, seq_err}, 32'd0);
        prog_sweep("R8 table unchanged");

        // R9 tight range survives unlocks
        cmd(6, 32'h0C);
        cmd(7, 32'h0D);
        chk("R9 tight op", {29'd0, last_op}, 32'd6);
        chk("R9 tight range", {last_lo[7:0], last_hi[7:0]}, 32'h0607);
        mdl[6] = 2; mdl[7] = 2;
        cmd(0, 32'h0E);
        for (int b = 0; b < 6; b++) mdl[b] = 0;
        cmd(6, 32'h08);
        cmd(7, 32'h09);
        chk("R9 unlock range op", {29'd0, last_op}, 32'd4);
        prog_sweep("R9 tight kept");

        // R11 / R6 erase and verify
        n0 = req_cnt;
        cmd(7, 32'h03);
        chk("R11 erase refused", 32'(req_cnt), 32'(n0));
        chk("R11 erase flag", {31'd0, locked_err}, 32'd1);
        clear_flags();
        cmd(0, 32'h03);
        chk("R6 erase op", {29'd0, last_op}, 32'd1);
        chk("R6 erase blk", {18'd0, last_lo}, 32'd0);
        cmd(7, 32'h15);
        chk("R6 verify op", {29'd0, last_op}, 32'd2);
        chk("R6 verify blk", {18'd0, last_hi}, 32'd7);

        // R2 / R14 wide block field, low bits select protection
        bus_op(1'b1, fa(2, 32'h1A3, 5, 2), 32'h03); settle();
        chk("R2 R14 erase wide lo", {18'd0, last_lo}, 32'h1A3);
        chk("R2 erase wide hi", {18'd0, last_hi}, 32'h1A3);

        // R13 unknown codes
        n0 = req_cnt;
        cmd(0, 32'h55);
        chk("R13 no request", 32'(req_cnt), 32'(n0));
        chk("R13 no flags", {30'd0, seq_err, locked_err}, 32'd0);

        // R10 stall window
        resp_delay = 3;
        bus_op(1'b1, fa(2, 0, 0, 0), 32'h15);
        n0 = 0;
        @(negedge clk);
        chk("R10 req_valid", {31'd0, req_valid}, 32'd1);
        while (!bus_ready) begin
            n0++;
            @(negedge clk);
        end
        chk("R10 stall length", 32'(n0), 32'd4);
        resp_delay = 0;

        report();
    end
endmodule